// File: doc/BRIEF.md
# Severity-Locked Memory Error Capture Register

This block keeps a record of the first memory-data ECC error reported by four checkers: the data array, the fill buffer, the store buffer and the mesh input. Each checker can report a correctable (single-bit) or an uncorrectable (multi-bit) error in any cycle. When the record is free, the block stores the error's address, security bit and octword index. It sets one flag that names the source and the severity. It also raises the matching bit in an interrupt status vector. ECC decoding and interrupt message delivery are done elsewhere.

The lock on the record depends on severity. A multi-bit record holds until software clears its flag. A single-bit record holds against other single-bit errors, but any multi-bit error replaces it. Software clears flags by writing ones to them. Interrupt status bits use the same write-one-to-clear scheme. Enables are set and cleared through separate write-one-to-set and write-one-to-clear inputs. If an interrupt handler reads the record with every flag at zero, an error was lost in a set/clear race.

Top module: `dat_err_capture`

## Requirements
- R1: After reset, `log_word`, `int_sts` and `int_en` are zero and `irq` is low.
- R2: `log_word` layout: octword at [5:4], address at [47:6], non-secure bit at [52], single-bit flags at [59:56] and multi-bit flags at [63:60]. Within each nibble the order is mesh (lowest bit), store buffer, fill buffer, data (highest bit). Input bit i of `sbe_det` and `mbe_det` follows the same source order. When the record is empty, the error with the highest priority is captured one cycle after it is reported. Multi-bit beats single-bit. Within one severity, data beats fill buffer, fill buffer beats store buffer, and store buffer beats mesh.
- R3: While a multi-bit flag is held and not cleared, later errors leave `log_word` unchanged.
- R4: While a single-bit flag is held, later single-bit errors are ignored. A multi-bit error replaces the record.
- R5: At most one of the eight flags is set at any time.
- R6: A capture from the mesh source sets only its flag. The address, non-secure and octword fields keep their previous values.
- R7: A one in `log_clr` (same bit layout as `log_word[63:56]`) clears that flag and frees the record. A one for a flag that is not set has no effect.
- R8: If the held flag is cleared in the same cycle as a new error is reported, the new error is captured.
- R9: Every reported error sets its `int_sts` bit, whether or not it was captured. `int_sts` uses the flag bit order. A one in `sts_clr` clears the bit, but a new report of that bit in the same cycle wins.
- R10: A one in `en_set` sets the `int_en` bit and a one in `en_clr` clears it. When both are set for the same bit, the clear wins.
- R11: `irq` is high exactly when some bit is set in both `int_sts` and `int_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbe_det | input | 4 | Single-bit error reports, bit 0 mesh .. bit 3 data |
| mbe_det | input | 4 | Multi-bit error reports, same order |
| err_addr | input | 42 | Address of the reported error |
| err_ns | input | 1 | Non-secure attribute of the reported error |
| err_ow | input | 2 | Octword index of the reported error |
| log_clr | input | 8 | Write-one-to-clear of record flags |
| sts_clr | input | 8 | Write-one-to-clear of interrupt status |
| en_set | input | 8 | Write-one-to-set of interrupt enables |
| en_clr | input | 8 | Write-one-to-clear of interrupt enables |
| log_word | output | 64 | Error record |
| int_sts | output | 8 | Interrupt status |
| int_en | output | 8 | Interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs these corner cases:
- Single-bit and multi-bit reports in the same cycle. A wrong priority order would record a single-bit flag, or the wrong source.
- A multi-bit error after a single-bit record. A design with a flat first-error lock would keep the stale single-bit record.
- A multi-bit error after a multi-bit record. A design without the lock would overwrite the record.
- A mesh capture. A design that loads every field would overwrite the previous address with data that means nothing.
- A clear of the held flag in the same cycle as a new error, and a status clear in the same cycle as a new report. A design that gets either race wrong would drop an error silently.

// File: rtl/dec_pkg.sv
package dec_pkg;
  // Field positions of the error record; a software decoder depends on them.
  parameter int NSRC      = 4;
  parameter int NFLAG     = 2 * NSRC;
  parameter int ADDR_W    = 42;
  parameter int OW_W      = 2;
  parameter int WORD_W    = 64;
  parameter int OW_LSB    = 4;
  parameter int ADDR_LSB  = 6;
  parameter int NS_BIT    = 52;
  parameter int FLAG_LSB  = 56;
  parameter int MESH_IDX  = 0;
endpackage

// File: rtl/ecap_pick.sv
module ecap_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] ev,
  output logic [N-1:0] win,
  output logic         any,
  output logic         sev
);
  // Highest set index wins: upper half is multi-bit, data at the top of each half.
  always_comb begin
    win = '0;
    for (int i = 0; i < N; i++) begin
      if (ev[i]) begin
        win    = '0;
        win[i] = 1'b1;
      end
    end
    any = |ev;
    sev = |win[N-1:N/2];
  end

  // R2
  always_comb begin
    win_onehot_chk: assert (!any || $onehot(win));
  end
endmodule

// File: rtl/ecap_log.sv
module ecap_log
  import dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  win,
  input  logic              any,
  input  logic              sev,
  input  logic              is_mesh,
  input  logic [NFLAG-1:0]  ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ns,
  input  logic [OW_W-1:0]   ow,
  input  logic [NFLAG-1:0]  log_clr,
  output logic [NFLAG-1:0]  flags_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ns_q,
  output logic [OW_W-1:0]   ow_q
);
  logic [NFLAG-1:0] eff, flags_d;
  logic held_mbe, held_sbe, take, info_en;

  always_comb begin
    eff      = flags_q & ~log_clr;
    held_mbe = |eff[NFLAG-1:NSRC];
    held_sbe = |eff[NSRC-1:0];
    take     = any && !held_mbe && (!held_sbe || sev);
    flags_d  = take ? win : eff;
    info_en  = take && !is_mesh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      addr_q  <= '0;
      ns_q    <= 1'b0;
      ow_q    <= '0;
    end else begin
      flags_q <= flags_d;
      if (info_en) begin
        addr_q <= addr;
        ns_q   <= ns;
        ow_q   <= ow;
      end
    end
  end

  // R5
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(flags_q));
  // R3
  mbe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags_q[NFLAG-1:NSRC]) && ((log_clr & flags_q) == '0)) |=> $stable(flags_q));
  // R6
  mesh_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any && is_mesh) |=> ($stable(addr_q) && $stable(ns_q) && $stable(ow_q)));
  // R8
  clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q != '0) && ((log_clr & flags_q) == flags_q) && (|ev)) |=> (flags_q != '0));
endmodule

// File: rtl/ecap_irq.sv
module ecap_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] sts_clr,
  input  logic [N-1:0] en_set,
  input  logic [N-1:0] en_clr,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] en_q,
  output logic         irq
);
  logic [N-1:0] sts_d, en_d;

  always_comb begin
    sts_d = (sts_q & ~sts_clr) | ev;
    en_d  = (en_q | en_set) & ~en_clr;
    irq   = |(sts_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  // R9
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((sts_q & $past(ev)) == $past(ev)));
  // R10
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr) |=> ((en_q & $past(en_clr)) == '0));
endmodule

// File: rtl/dat_err_capture.sv
module dat_err_capture
  import dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   sbe_det,
  input  logic [NSRC-1:0]   mbe_det,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              err_ns,
  input  logic [OW_W-1:0]   err_ow,
  input  logic [NFLAG-1:0]  log_clr,
  input  logic [NFLAG-1:0]  sts_clr,
  input  logic [NFLAG-1:0]  en_set,
  input  logic [NFLAG-1:0]  en_clr,
  output logic [WORD_W-1:0] log_word,
  output logic [NFLAG-1:0]  int_sts,
  output logic [NFLAG-1:0]  int_en,
  output logic              irq
);
  logic [NFLAG-1:0]  ev, win, flags_q;
  logic              any, sev, is_mesh, ns_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OW_W-1:0]   ow_q;

  assign ev      = {mbe_det, sbe_det};
  assign is_mesh = win[MESH_IDX] | win[NSRC + MESH_IDX];

  ecap_pick #(.N(NFLAG)) u_pick (
    .ev(ev), .win(win), .any(any), .sev(sev)
  );

  ecap_log u_log (
    .clk(clk), .rst_n(rst_n), .win(win), .any(any), .sev(sev),
    .is_mesh(is_mesh), .ev(ev), .addr(err_addr), .ns(err_ns), .ow(err_ow),
    .log_clr(log_clr), .flags_q(flags_q), .addr_q(addr_q), .ns_q(ns_q), .ow_q(ow_q)
  );

  ecap_irq #(.N(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .sts_clr(sts_clr), .en_set(en_set),
    .en_clr(en_clr), .sts_q(int_sts), .en_q(int_en), .irq(irq)
  );

  always_comb begin
    log_word = '0;
    log_word[FLAG_LSB +: NFLAG]  = flags_q;
    log_word[NS_BIT]             = ns_q;
    log_word[ADDR_LSB +: ADDR_W] = addr_q;
    log_word[OW_LSB +: OW_W]     = ow_q;
  end
endmodule

// File: tb/tb_dat_err_capture.sv
module tb_dat_err_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sbe_det = '0, mbe_det = '0;
  logic [41:0] err_addr = '0;
  logic        err_ns = 1'b0;
  logic [1:0]  err_ow = '0;
  logic [7:0]  log_clr = '0, sts_clr = '0, en_set = '0, en_clr = '0;
  logic [63:0] log_word;
  logic [7:0]  int_sts, int_en;
  logic        irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dat_err_capture dut (.*);

  // Behavioural reference model
  logic [7:0]  m_flags, m_sts, m_en;
  logic [41:0] m_addr;
  logic        m_ns;
  logic [1:0]  m_ow;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0; m_sts = 0; m_en = 0; m_addr = 0; m_ns = 0; m_ow = 0;
    end else begin
      automatic logic [7:0] evv = {mbe_det, sbe_det};
      automatic logic [7:0] eff = m_flags & ~log_clr;
      automatic int w = -1;
      automatic bit take;
      for (int i = 7; i >= 0; i--) if (w < 0 && evv[i]) w = i;
      take = (w >= 0) && (eff == 0 || (eff[7:4] == 0 && w >= 4));
      if (take) begin
        m_flags = 8'(1 << w);
        if (w != 0 && w != 4) begin m_addr = err_addr; m_ns = err_ns; m_ow = err_ow; end
      end else m_flags = eff;
      m_sts = (m_sts & ~sts_clr) | evv;
      m_en  = (m_en | en_set) & ~en_clr;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 model log_word", log_word,
          {m_flags, 3'b000, m_ns, 4'b0000, m_addr, m_ow, 4'b0000});
      chk("R9 model int_sts", {56'd0, int_sts}, {56'd0, m_sts});
      chk("R10 model int_en", {56'd0, int_en}, {56'd0, m_en});
      chk("R11 model irq", {63'd0, irq}, {63'd0, |(m_sts & m_en)});
    end
  end

  task automatic apply(input logic [3:0] s, input logic [3:0] m, input logic [41:0] a,
                       input logic n, input logic [1:0] o, input logic [7:0] lc,
                       input logic [7:0] sc, input logic [7:0] es, input logic [7:0] ec);
    sbe_det = s; mbe_det = m; err_addr = a; err_ns = n; err_ow = o;
    log_clr = lc; sts_clr = sc; en_set = es; en_clr = ec;
    @(negedge clk);
    sbe_det = 0; mbe_det = 0; log_clr = 0; sts_clr = 0; en_set = 0; en_clr = 0;
  endtask

  localparam logic [41:0] A1 = 42'h0123456789A, A2 = 42'h2BBBBBBBBBB, A3 = 42'h1C0FFEE1234,
                          A4 = 42'h3DDDDDDDDDD, A5 = 42'h05555555555, A6 = 42'h2A5A5A5A5A5,
                          A7 = 42'h17777777777;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 log_word", log_word, 64'd0);
    chk("R1 int_sts", {56'd0, int_sts}, 64'd0);
    chk("R1 int_en", {56'd0, int_en}, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    // R2: store and mesh single-bit together, store wins
    apply(4'b0011, 4'b0000, A1, 1'b1, 2'd2, 0, 0, 0, 0);
    chk("R2 flags", {56'd0, log_word[63:56]}, 64'h02);
    chk("R2 addr", {22'd0, log_word[47:6]}, {22'd0, A1});
    chk("R2 ns/ow", {61'd0, log_word[52], log_word[5:4]}, 64'd6);
    // R4: later single-bit ignored
    apply(4'b1000, 4'b0000, A2, 1'b0, 2'd1, 0, 0, 0, 0);
    chk("R4 sbe ignored", {56'd0, log_word[63:56]}, 64'h02);
    chk("R4 addr kept", {22'd0, log_word[47:6]}, {22'd0, A1});
    // R4 / R2: multi-bit fill beats single-bit data and overwrites
    apply(4'b1000, 4'b0100, A3, 1'b0, 2'd3, 0, 0, 0, 0);
    chk("R4 mbe overwrite", {56'd0, log_word[63:56]}, 64'h40);
    chk("R4 addr new", {22'd0, log_word[47:6]}, {22'd0, A3});
    // R5
    chk("R5 one flag", 64'($countones(log_word[63:56])), 64'd1);
    // R3: multi-bit data ignored while multi-bit held
    apply(4'b0000, 4'b1000, A4, 1'b1, 2'd0, 0, 0, 0, 0);
    chk("R3 locked", log_word, {8'h40, 3'b0, 1'b0, 4'b0, A3, 2'd3, 4'b0});
    // R9: uncaptured errors still set status
    chk("R9 status", {56'd0, int_sts}, 64'hCB);
    // R7: clear of a flag not set
    apply(0, 0, A4, 1'b1, 2'd0, 8'h80, 0, 0, 0);
    chk("R7 noop clear", {56'd0, log_word[63:56]}, 64'h40);
    // R8 + R6: clear races with mesh error
    apply(4'b0001, 0, A5, 1'b1, 2'd1, 8'h40, 0, 0, 0);
    chk("R8 race capture", {56'd0, log_word[63:56]}, 64'h01);
    chk("R6 mesh keeps info", log_word[55:0], {3'b0, 1'b0, 4'b0, A3, 2'd3, 4'b0});
    // R7: clear releases lock
    apply(0, 0, 0, 0, 0, 8'h01, 0, 0, 0);
    chk("R7 cleared", {56'd0, log_word[63:56]}, 64'h00);
    apply(4'b0100, 0, A6, 1'b1, 2'd2, 0, 0, 0, 0);
    chk("R7 recapture", log_word, {8'h04, 3'b0, 1'b1, 4'b0, A6, 2'd2, 4'b0});
    // R10 / R11
    apply(0, 0, 0, 0, 0, 0, 0, 8'h04, 0);
    chk("R10 enable set", {56'd0, int_en}, 64'h04);
    chk("R11 irq high", {63'd0, irq}, 64'd1);
    apply(0, 0, 0, 0, 0, 0, 8'h04, 0, 0);
    chk("R9 status clear", {56'd0, int_sts}, 64'hCB);
    chk("R11 irq low", {63'd0, irq}, 64'd0);
    apply(0, 0, 0, 0, 0, 0, 0, 8'h01, 8'h01);
    chk("R10 clear wins", {56'd0, int_en}, 64'h04);
    // R9 set wins over clear; R6 mesh multi-bit overwrite keeps info
    apply(0, 4'b0001, A7, 1'b0, 2'd0, 0, 8'h10, 0, 0);
    chk("R9 set wins", {56'd0, int_sts}, 64'hDB);
    chk("R6 mesh mbe", log_word, {8'h10, 3'b0, 1'b1, 4'b0, A6, 2'd2, 4'b0});
    // Random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      apply(4'($urandom & $urandom & $urandom), 4'($urandom & $urandom & $urandom),
            42'({$urandom, $urandom}), 1'($urandom), 2'($urandom),
            ($urandom % 4 == 0) ? log_word[63:56] : 8'($urandom & $urandom & $urandom),
            8'($urandom & $urandom), 8'($urandom & $urandom & $urandom),
            8'($urandom & $urandom & $urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule